// File: doc/BRIEF.md
# Annunciator Soft Switch Controller

This block sits on a CPU bus and watches for accesses to a small window of I/O locations. It keeps four annunciator output levels and a double-resolution graphics mode flag. Eight consecutive locations form four clear/set pairs, one pair for each annunciator. An even location clears its annunciator and an odd location sets it. Both reads and writes act on these locations.

The fourth annunciator is tied inversely to the graphics mode flag. Clearing it turns the flag on, and setting it turns the flag off. One extra location serves two purposes. Any access to it starts the paddle timers. A read of it also returns the graphics flag in bit 7 of the read data.

The CPU presents a 16-bit address, a read/write strobe and a bus-valid strobe. All outputs are registered and change on the clock edge that samples the access. Software sees the new levels, the trigger pulse and the read data in the following cycle.

Top module: `annun_switch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all four annunciators are 0, the mode flag is 0, the trigger is 0, the read enable is 0 and the read data is 0x00.
- R2: A qualified access (valid=1) to address 0xC058+2n+b, with n from 0 to 3 and b from 0 to 1, sets annunciator n to b in the next cycle. This holds for reads and writes alike. The other annunciators keep their values.
- R3: An access to 0xC05E makes the mode flag 1, and an access to 0xC05F makes it 0. No other access changes the flag.
- R4: A read of any of the eight locations 0xC058 to 0xC05F gives read enable 1 and read data 0x00 in the next cycle.
- R5: A read of 0xC07F gives read enable 1 in the next cycle. The read data is 0x80 if the mode flag was 1 when the read was made, and 0x00 otherwise.
- R6: Any qualified access to 0xC07F, read or write, makes the trigger 1 for exactly the next cycle. Back-to-back accesses give one pulse cycle each. No other access raises the trigger.
- R7: A write to 0xC07F gives no read enable and changes neither the annunciators nor the flag.
- R8: An access to any other address, or any cycle with valid=0, changes no state. It gives read enable 0, read data 0x00 and trigger 0 in the next cycle. This includes addresses that differ from a decoded location only in the upper bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | CPU address |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_valid | input | 1 | Qualifies the access for this cycle |
| ann | output | 4 | Annunciator levels, bit n is annunciator n |
| dres_mode | output | 1 | Double-resolution graphics mode flag |
| paddle_trig | output | 1 | One-cycle paddle timer start pulse |
| rd_en | output | 1 | Read data valid for a decoded read |
| rd_data | output | 8 | Read data |

## Verification
The bench targets the shared location 0xC07F in several ways. A design that ignored the read/write strobe there would raise a read enable on writes. A design that sampled the flag one cycle late would return the wrong bit 7 right after a toggle. The bench sends back-to-back accesses to that location, which a design that only produced an edge-detected pulse would merge into one. It also checks the inverse tie on annunciator 3: a swapped polarity would leave the flag equal to the annunciator. The bench aims aliases that match only the low address bits at the decoder, along with cycles where valid is low, so a partial decode or an unqualified strobe changes state where it must not.

// File: rtl/annun_switch.sv
module annun_switch #(
  parameter logic [15:0] ANN_BASE  = 16'hC058,
  parameter logic [15:0] TRIG_ADDR = 16'hC07F,
  parameter int          N_ANN     = 4,
  parameter int          DW        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      bus_addr,
  input  logic             bus_rd,
  input  logic             bus_valid,
  output logic [N_ANN-1:0] ann,
  output logic             dres_mode,
  output logic             paddle_trig,
  output logic             rd_en,
  output logic [DW-1:0]    rd_data
);
  localparam int SELW = (N_ANN > 1) ? $clog2(N_ANN) : 1;
  localparam int TOP  = SELW + 1;

  logic               ann_hit, trig_hit;
  logic [SELW-1:0]    sel;
  logic [N_ANN-1:0]   ann_q;
  logic               dres_q, trig_q, rden_q;
  logic [DW-1:0]      rdata_q;

  assign ann_hit  = bus_valid && (bus_addr[15:TOP] == ANN_BASE[15:TOP]);
  assign trig_hit = bus_valid && (bus_addr == TRIG_ADDR);
  assign sel      = bus_addr[SELW:1];

  for (genvar i = 0; i < N_ANN; i++) begin : g_ann
    always_ff @(posedge clk) begin
      if (!rst_n)
        ann_q[i] <= 1'b0;
      else if (ann_hit && sel == SELW'(i))
        ann_q[i] <= bus_addr[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dres_q  <= 1'b0;
      trig_q  <= 1'b0;
      rden_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (ann_hit && sel == SELW'(N_ANN - 1))
        dres_q <= ~bus_addr[0];
      trig_q  <= trig_hit;
      rden_q  <= bus_rd && (ann_hit || trig_hit);
      rdata_q <= (bus_rd && trig_hit) ? {dres_q, {(DW-1){1'b0}}} : '0;
    end
  end

  assign ann         = ann_q;
  assign dres_mode   = dres_q;
  assign paddle_trig = trig_q;
  assign rd_en       = rden_q;
  assign rd_data     = rdata_q;
endmodule

// File: rtl/annun_switch_chk.sv
module annun_switch_chk #(
  parameter logic [15:0] ANN_BASE  = 16'hC058,
  parameter logic [15:0] TRIG_ADDR = 16'hC07F,
  parameter int          N_ANN     = 4,
  parameter int          DW        = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [15:0]      bus_addr,
  input logic             bus_rd,
  input logic             bus_valid,
  input logic [N_ANN-1:0] ann,
  input logic             dres_mode,
  input logic             paddle_trig,
  input logic             rd_en,
  input logic [DW-1:0]    rd_data
);
  localparam int TOP = ((N_ANN > 1) ? $clog2(N_ANN) : 1) + 1;

  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  logic in_win, at_trig;
  assign in_win  = bus_valid && (bus_addr[15:TOP] == ANN_BASE[15:TOP]);
  assign at_trig = bus_valid && (bus_addr == TRIG_ADDR);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (ann == '0 && !dres_mode && !paddle_trig && !rd_en));

  a_r2_ann_stable: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(in_win) |-> $stable(ann));

  a_r3_flag_inverse: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $changed(dres_mode) |-> (dres_mode != ann[N_ANN-1]));

  a_r5_rdata_shape: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_data[DW-2:0] == '0));

  a_r6_trig_source: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    paddle_trig |-> $past(at_trig));

  a_r7_rden_source: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    rd_en |-> $past(bus_rd && (in_win || at_trig)));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(bus_valid) |-> (!rd_en && !paddle_trig && rd_data == '0));
endmodule

bind annun_switch annun_switch_chk #(
  .ANN_BASE(ANN_BASE), .TRIG_ADDR(TRIG_ADDR), .N_ANN(N_ANN), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_valid(bus_valid), .ann(ann), .dres_mode(dres_mode),
  .paddle_trig(paddle_trig), .rd_en(rd_en), .rd_data(rd_data)
);

// File: tb/annun_switch_tb.sv
module annun_switch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_valid = 1'b0;
  logic [3:0]  ann;
  logic        dres_mode, paddle_trig, rd_en;
  logic [7:0]  rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  annun_switch u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_valid(bus_valid), .ann(ann), .dres_mode(dres_mode),
    .paddle_trig(paddle_trig), .rd_en(rd_en), .rd_data(rd_data)
  );

  logic [3:0] m_ann = '0;
  logic       m_dres = 1'b0;

  function automatic bit is_ann(logic [15:0] a);
    return a >= 16'hC058 && a <= 16'hC05F;
  endfunction

  function automatic bit is_trig(logic [15:0] a);
    return a == 16'hC07F;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(logic [15:0] a, logic rd, logic v);
    logic       e_trig, e_rden;
    logic [7:0] e_data;
    string      tg;
    bus_addr = a; bus_rd = rd; bus_valid = v;
    e_trig = v && is_trig(a);
    e_rden = v && rd && (is_ann(a) || is_trig(a));
    e_data = (v && rd && is_trig(a)) ? {m_dres, 7'b0} : 8'h00;
    if (v && is_ann(a)) begin
      m_ann[a[2:1]] = a[0];
      if (a[2:1] == 2'd3) m_dres = ~a[0];
    end
    tg = !v ? "R8" : is_ann(a) ? (a[2:1] == 2'd3 ? "R3" : "R2")
       : is_trig(a) ? (rd ? "R5" : "R7") : "R8";
    @(posedge clk);
    @(negedge clk);
    chk(tg, 16'(ann), 16'(m_ann), "ann");
    chk(tg == "R2" ? "R2" : tg, 16'(dres_mode), 16'(m_dres), "dres_mode");
    chk("R6", 16'(paddle_trig), 16'(e_trig), "paddle_trig");
    chk(is_ann(a) && v && rd ? "R4" : tg, 16'(rd_en), 16'(e_rden), "rd_en");
    chk(is_ann(a) && v && rd ? "R4" : tg, 16'(rd_data), 16'(e_data), "rd_data");
  endtask

  initial begin
    bit hung;
    hung = 1'b0;
    fork
      begin
        logic [15:0] ra;
        int          k;
        repeat (3) @(negedge clk);
        chk("R1", 16'({ann, dres_mode, paddle_trig, rd_en}), 16'h0, "reset outs");
        chk("R1", 16'(rd_data), 16'h0, "reset rd_data");
        rst_n = 1'b1;
        access(16'h0000, 1'b0, 1'b0);
        chk("R1", 16'(ann), 16'h0, "post-reset ann");
        access(16'hC05E, 1'b1, 1'b1);
        access(16'hC07F, 1'b1, 1'b1);
        access(16'hC07F, 1'b1, 1'b1);
        access(16'hC05F, 1'b0, 1'b1);
        access(16'hC07F, 1'b0, 1'b1);
        access(16'hC07F, 1'b1, 1'b1);
        access(16'hC059, 1'b0, 1'b0);
        access(16'hC05B, 1'b0, 1'b1);
        access(16'h405B, 1'b1, 1'b1);
        access(16'hC05A, 1'b1, 1'b1);
        access(16'hC057, 1'b0, 1'b1);
        access(16'hC060, 1'b1, 1'b1);
        access(16'hC05E, 1'b0, 1'b1);
        access(16'h407F, 1'b1, 1'b1);
        access(16'hC07F, 1'b1, 1'b1);
        void'($urandom(32'd4242));
        for (int i = 0; i < 600; i++) begin
          k = int'($urandom % 8);
          if (k < 4)       ra = 16'hC058 + 16'($urandom % 8);
          else if (k == 4) ra = 16'hC07F;
          else if (k == 5) ra = 16'hC050 + 16'($urandom % 48);
          else if (k == 6) ra = {4'($urandom), 12'h05F};
          else             ra = 16'($urandom);
          access(ra, 1'($urandom), ($urandom % 5) != 0);
        end
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        hung = !done;
      end
    join_any
    if (hung || !done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule